// File: doc/BRIEF.md
# Ping-Pong Isochronous IN Endpoint Buffer

This block is the transmit store for a single isochronous IN endpoint, plus the matching receive store for the OUT direction. Firmware pushes bytes one at a time into the bank selected by the write pointer, then marks that bank ready. When the serial engine reports an IN token for the endpoint, the block streams the bank the read pointer selects, one byte per cycle. If that bank is not ready, the token produces no output at all: isochronous traffic carries no handshake. Once a packet has been fully sent, the block sets a per-bank complete flag, empties the bank, and raises a level interrupt request while any complete flag is pending and interrupts are enabled.

In standard mode only bank 0 is used. In ping-pong mode, each accepted ready command moves the write pointer to the other bank, so firmware can fill bank 1 while bank 0 waits for the host. The read pointer moves to the other bank after each finished transmission. Dropping the endpoint enable flushes both banks and clears every flag and pointer. The OUT path stores up to one bank's depth of incoming bytes, discards the rest, and still reports the packet good when the externally checked CRC is good.

The transmit controller has three states. IDLE waits for a token. SEND drives one stored byte per cycle. FINISH is a single cycle that posts the completion. The transitions are: IDLE to SEND on a token to a ready, non-empty bank; IDLE to FINISH on a token to a ready, empty bank; SEND to FINISH on the last byte; FINISH to IDLE always; and any state to IDLE while the endpoint is disabled.

Top module: `iso_in_epbuf`

## Requirements
- R1: While `cfg_enable` is low, tokens and firmware writes are ignored. Both banks are emptied, all ready, complete and overflow flags are cleared, and both bank pointers return to bank 0. `tx_valid`, `tx_empty` and `irq` are low from the next cycle on.
- R2: Firmware bytes are appended in order to the write bank. After `fw_set_ready`, the next `usb_in_token` makes the block drive the stored bytes in write order, one per cycle, starting the cycle after the token. `tx_last` marks the final byte.
- R3: A token that addresses a bank whose ready flag is clear produces no `tx_valid` and no `tx_empty`, and leaves the read pointer where it was.
- R4: After a packet has been sent, the sent bank's ready flag clears, its byte count returns to zero and its complete flag sets. `st_done` shows the complete flag of the most recently sent bank. `fw_clr_done` clears that flag, and if the other bank's flag is still pending, the status then moves to that bank.
- R5: `irq` is high exactly while `cfg_irq_en` is high and at least one complete flag is set.
- R6: Byte writes and ready commands aimed at a bank whose ready or complete flag is set are dropped.
- R7: In ping-pong mode, each accepted ready command toggles the write bank (`st_wr_bank`). In standard mode the write bank stays 0.
- R8: In ping-pong mode, the read pointer starts at bank 0 and toggles after each completed transmission. An unanswered token does not move it.
- R9: A bank holds `DEPTH` bytes. Writes beyond that are dropped and set `st_overflow`, which stays set until the endpoint is disabled.
- R10: A token to a ready bank holding zero bytes produces one `tx_empty` pulse and no `tx_valid`, and then completes as in R4.
- R11: On the OUT path, up to `DEPTH` bytes of a packet are stored and the rest are discarded. At `out_end`, `rx_len` is loaded with the stored count and `rx_pkt_ok` pulses for one cycle if `out_crc_ok` is high, whether or not bytes were discarded.
- R12: Tokens that arrive while a packet is being sent are ignored. The packet finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Endpoint enabled and configured; low flushes the endpoint |
| cfg_pingpong | input | 1 | 1 = two-bank mode, 0 = single bank |
| cfg_irq_en | input | 1 | Interrupt enable for complete flags |
| fw_wr_valid | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | DW | Firmware byte |
| fw_set_ready | input | 1 | Mark the write bank ready |
| fw_clr_done | input | 1 | Clear the displayed complete flag |
| st_wr_bank | output | 1 | Current write bank |
| st_ready | output | 1 | Ready flag of the write bank |
| st_done | output | 1 | Complete flag of the last sent bank |
| st_overflow | output | 1 | Sticky firmware overflow |
| irq | output | 1 | Level interrupt request |
| usb_in_token | input | 1 | IN token pulse for this endpoint |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | DW | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_empty | output | 1 | Zero-length packet pulse |
| out_valid | input | 1 | OUT byte strobe |
| out_data | input | DW | OUT byte |
| out_end | input | 1 | End of OUT packet |
| out_crc_ok | input | 1 | CRC good, sampled with `out_end` |
| rx_rd_addr | input | AW | Read address into the OUT store |
| rx_rd_data | output | DW | OUT store byte at `rx_rd_addr` |
| rx_len | output | CW | Stored length of the last OUT packet |
| rx_pkt_ok | output | 1 | One-cycle good-packet pulse |

## Verification
On every cycle, the assertions check that a disabled endpoint stays silent and that no byte goes out unless the read bank is ready. They also check that a token to an unready bank yields nothing, that a packet in flight cannot be cut short or restarted by another token, that the interrupt only rises on a completion or an enable, that the overflow bit is sticky, and that the OUT length never exceeds the depth. The remaining behaviour can only be shown by the bench's scenarios: byte order and packet length, the alternation of the two bank pointers, the dropping of writes to busy banks, the flush on disable, the zero-length pulse, and the stored contents of an oversized OUT packet.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_FINISH = 2'd2
    } tx_state_e;
endpackage

// File: rtl/epbuf_bank.sv
// One byte store with an append counter; writes past DEPTH are ignored.
module epbuf_bank #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];

    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en && !full && !clr) begin
            mem[count[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (wr_en && !full) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/epbuf_rx.sv
// OUT-direction store: keeps up to DEPTH bytes, reports length and CRC verdict.
module epbuf_rx #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_end,
    input  logic          in_crc_ok,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] pkt_len,
    output logic          pkt_ok
);
    logic [CW-1:0] fill;
    logic          fill_full;

    epbuf_bank #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush || in_end),
        .wr_en   (in_valid && !flush),
        .wr_data (in_data),
        .rd_idx  (rd_addr),
        .rd_data (rd_data),
        .count   (fill),
        .full    (fill_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_len <= '0;
            pkt_ok  <= 1'b0;
        end else if (flush) begin
            pkt_len <= '0;
            pkt_ok  <= 1'b0;
        end else begin
            pkt_ok <= in_end && in_crc_ok;
            if (in_end) begin
                pkt_len <= fill;
            end
        end
    end
endmodule

// File: rtl/iso_in_epbuf.sv
module iso_in_epbuf
    import iso_in_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NB   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_pingpong,
    input  logic          cfg_irq_en,
    input  logic          fw_wr_valid,
    input  logic [DW-1:0] fw_wr_data,
    input  logic          fw_set_ready,
    input  logic          fw_clr_done,
    output logic          st_wr_bank,
    output logic          st_ready,
    output logic          st_done,
    output logic          st_overflow,
    output logic          irq,
    input  logic          usb_in_token,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    output logic          tx_empty,
    input  logic          out_valid,
    input  logic [DW-1:0] out_data,
    input  logic          out_end,
    input  logic          out_crc_ok,
    input  logic [AW-1:0] rx_rd_addr,
    output logic [DW-1:0] rx_rd_data,
    output logic [CW-1:0] rx_len,
    output logic          rx_pkt_ok
);
    tx_state_e     state_q, state_d;
    logic [AW-1:0] idx_q;
    logic          wr_bank_q, rd_bank_q, last_q;
    logic [NB-1:0] ready_q, done_q;
    logic          ovf_q;

    logic [DW-1:0] bk_rd_data [NB];
    logic [CW-1:0] bk_cnt     [NB];
    logic [NB-1:0] bk_full;

    logic          wr_blocked, fw_wr_ok, rd_ready, last_byte;
    logic [CW-1:0] rd_cnt;

    assign wr_blocked = ready_q[wr_bank_q] | done_q[wr_bank_q];
    assign fw_wr_ok   = cfg_enable && fw_wr_valid && !wr_blocked;
    assign rd_ready   = ready_q[rd_bank_q];
    assign rd_cnt     = bk_cnt[rd_bank_q];
    assign last_byte  = (CW'(idx_q) == rd_cnt - CW'(1));

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic BSEL = 1'(b);
        epbuf_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (!cfg_enable || (state_q == ST_FINISH && rd_bank_q == BSEL)),
            .wr_en   (fw_wr_ok && wr_bank_q == BSEL),
            .wr_data (fw_wr_data),
            .rd_idx  (idx_q),
            .rd_data (bk_rd_data[b]),
            .count   (bk_cnt[b]),
            .full    (bk_full[b])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (usb_in_token && rd_ready) begin
                    state_d = (rd_cnt == '0) ? ST_FINISH : ST_SEND;
                end
            end
            ST_SEND: begin
                if (last_byte) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!cfg_enable) state_d = ST_IDLE;
    end

    // State register and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_q == ST_SEND && state_d == ST_SEND) ? idx_q + AW'(1) : '0;
        end
    end

    // Outputs
    always_comb begin
        tx_valid = (state_q == ST_SEND);
        tx_data  = bk_rd_data[rd_bank_q];
        tx_last  = (state_q == ST_SEND) && last_byte;
        tx_empty = (state_q == ST_FINISH) && (rd_cnt == '0);
    end

    // Bank pointers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bank_q <= 1'b0;
            rd_bank_q <= 1'b0;
            last_q    <= 1'b0;
            ready_q   <= '0;
            done_q    <= '0;
            ovf_q     <= 1'b0;
        end else if (!cfg_enable) begin
            wr_bank_q <= 1'b0;
            rd_bank_q <= 1'b0;
            last_q    <= 1'b0;
            ready_q   <= '0;
            done_q    <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (fw_clr_done) begin
                done_q[last_q] <= 1'b0;
                if (cfg_pingpong && done_q[~last_q]) last_q <= ~last_q;
            end
            if (fw_set_ready && !wr_blocked) begin
                ready_q[wr_bank_q] <= 1'b1;
                if (cfg_pingpong) wr_bank_q <= ~wr_bank_q;
            end
            if (fw_wr_valid && !wr_blocked && bk_full[wr_bank_q]) begin
                ovf_q <= 1'b1;
            end
            if (state_q == ST_FINISH) begin
                ready_q[rd_bank_q] <= 1'b0;
                done_q[rd_bank_q]  <= 1'b1;
                last_q             <= rd_bank_q;
                if (cfg_pingpong) rd_bank_q <= ~rd_bank_q;
            end
        end
    end

    assign st_wr_bank  = wr_bank_q;
    assign st_ready    = ready_q[wr_bank_q];
    assign st_done     = done_q[last_q];
    assign st_overflow = ovf_q;
    assign irq         = cfg_irq_en && (done_q != '0);

    epbuf_rx #(.DW(DW), .DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!cfg_enable),
        .in_valid  (out_valid),
        .in_data   (out_data),
        .in_end    (out_end),
        .in_crc_ok (out_crc_ok),
        .rd_addr   (rx_rd_addr),
        .rd_data   (rx_rd_data),
        .pkt_len   (rx_len),
        .pkt_ok    (rx_pkt_ok)
    );
endmodule

// File: rtl/iso_in_epbuf_chk.sv
module iso_in_epbuf_chk
    import iso_in_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          cfg_irq_en,
    input logic          usb_in_token,
    input logic          tx_valid,
    input logic          tx_last,
    input logic          tx_empty,
    input logic          irq,
    input logic          st_overflow,
    input logic [CW-1:0] rx_len,
    input tx_state_e     state_q,
    input logic          rd_ready
);
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!tx_valid && !tx_empty && !irq));

    assert_send_from_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> rd_ready);

    assert_unready_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && usb_in_token && !rd_ready) |=> (!tx_valid && !tx_empty));

    assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(state_q) == ST_FINISH || $rose(cfg_irq_en)));

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overflow && cfg_enable) |=> st_overflow);

    assert_rx_len_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_len <= CW'(DEPTH));

    assert_packet_runs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last && cfg_enable) |=> tx_valid);
endmodule

bind iso_in_epbuf iso_in_epbuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_irq_en   (cfg_irq_en),
    .usb_in_token (usb_in_token),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_empty     (tx_empty),
    .irq          (irq),
    .st_overflow  (st_overflow),
    .rx_len       (rx_len),
    .state_q      (state_q),
    .rd_ready     (rd_ready)
);

// File: tb/iso_in_epbuf_tb.sv
module iso_in_epbuf_tb;
    localparam int DW    = 8;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0, cfg_pingpong = 1'b0, cfg_irq_en = 1'b0;
    logic          fw_wr_valid = 1'b0, fw_set_ready = 1'b0, fw_clr_done = 1'b0;
    logic [DW-1:0] fw_wr_data = '0;
    logic          st_wr_bank, st_ready, st_done, st_overflow, irq;
    logic          usb_in_token = 1'b0;
    logic          tx_valid, tx_last, tx_empty;
    logic [DW-1:0] tx_data;
    logic          out_valid = 1'b0, out_end = 1'b0, out_crc_ok = 1'b0;
    logic [DW-1:0] out_data = '0;
    logic [AW-1:0] rx_rd_addr = '0;
    logic [DW-1:0] rx_rd_data;
    logic [CW-1:0] rx_len;
    logic          rx_pkt_ok;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] got [0:127];
    int            got_n;
    int            last_at;
    bit            saw_empty;

    always #2 clk = ~clk;

    iso_in_epbuf #(.DW(DW), .DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fw_write(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fw_wr_valid = 1'b1;
            fw_wr_data  = DW'(base + i);
        end
        @(negedge clk);
        fw_wr_valid = 1'b0;
    endtask

    task automatic fw_ready();
        @(negedge clk); fw_set_ready = 1'b1;
        @(negedge clk); fw_set_ready = 1'b0;
    endtask

    task automatic fw_clear();
        @(negedge clk); fw_clr_done = 1'b1;
        @(negedge clk); fw_clr_done = 1'b0;
    endtask

    // Token pulse, then gather the reply; extra_at injects a second token mid-packet.
    task automatic send_collect(input int extra_at);
        got_n = 0; last_at = -1; saw_empty = 1'b0;
        @(negedge clk); usb_in_token = 1'b1;
        @(negedge clk); usb_in_token = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (tx_valid) begin
                got[got_n] = tx_data;
                if (tx_last) last_at = got_n;
                got_n++;
            end
            if (tx_empty) saw_empty = 1'b1;
            if (tx_last || tx_empty) break;
            @(negedge clk);
            usb_in_token = (got_n == extra_at) ? 1'b1 : 1'b0;
        end
        usb_in_token = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_silence(input string req);
        bit seen = 1'b0;
        @(negedge clk); usb_in_token = 1'b1;
        @(negedge clk); usb_in_token = 1'b0;
        for (int c = 0; c < 4; c++) begin
            if (tx_valid || tx_empty) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    task automatic check_bytes(input int n, input int base, input string req);
        chk(got_n == n, req, got_n, n);
        chk(last_at == n - 1, req, last_at, n - 1);
        for (int i = 0; i < n && i < got_n; i++) begin
            if (got[i] != DW'(base + i)) chk(1'b0, req, int'(got[i]), (base + i) % 256);
        end
    endtask

    task automatic set_enable(input bit en, input bit pp);
        @(negedge clk);
        cfg_enable = en; cfg_pingpong = pp;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!tx_valid && !tx_empty, "R1 reset tx idle", int'(tx_valid), 0);
        chk(!irq && !st_done && !st_ready, "R1 reset flags", int'(irq), 0);
        chk(!st_wr_bank && !st_overflow, "R1 reset bank/ovf", int'(st_wr_bank), 0);
        fw_write(2, 1);
        fw_ready();
        chk(!st_ready, "R1 disabled ignores ready", int'(st_ready), 0);
    endtask

    task automatic t_standard();
        set_enable(1'b1, 1'b0);
        cfg_irq_en = 1'b1;
        expect_silence("R3 standard not ready");
        fw_write(5, 8'h40);
        fw_ready();
        chk(st_ready, "R2 ready set", int'(st_ready), 1);
        chk(!st_wr_bank, "R7 standard stays bank0", int'(st_wr_bank), 0);
        send_collect(-1);
        check_bytes(5, 8'h40, "R2 standard packet");
        chk(st_done && !st_ready, "R4 done set ready clear", int'(st_done), 1);
        chk(irq, "R5 irq on done", int'(irq), 1);
        fw_write(1, 8'hEE);
        fw_ready();
        chk(!st_ready, "R6 ready dropped while done", int'(st_ready), 0);
        fw_clear();
        chk(!st_done && !irq, "R4 clear done", int'(irq), 0);
        fw_write(4, 8'h60);
        fw_ready();
        send_collect(2);
        check_bytes(4, 8'h60, "R6 R12 packet after clear");
        expect_silence("R12 no extra packet");
        fw_clear();
    endtask

    task automatic t_overflow();
        fw_write(DEPTH + 3, 0);
        chk(st_overflow, "R9 overflow flag", int'(st_overflow), 1);
        fw_ready();
        send_collect(-1);
        check_bytes(DEPTH, 0, "R9 capped packet");
        chk(st_overflow, "R9 overflow sticky", int'(st_overflow), 1);
        set_enable(1'b0, 1'b0);
        chk(!st_overflow && !st_done && !irq, "R1 flush on disable", int'(st_overflow), 0);
        set_enable(1'b1, 1'b0);
        fw_ready();
        send_collect(-1);
        chk(saw_empty && got_n == 0, "R10 zero-length pulse", got_n, 0);
        chk(st_done, "R10 completes", int'(st_done), 1);
    endtask

    task automatic t_pingpong();
        set_enable(1'b0, 1'b0);
        set_enable(1'b1, 1'b1);
        fw_write(3, 8'h10);
        fw_ready();
        chk(st_wr_bank, "R7 switch to bank1", int'(st_wr_bank), 1);
        send_collect(-1);
        check_bytes(3, 8'h10, "R8 bank0 first");
        chk(st_done && irq, "R4 R5 bank0 done", int'(irq), 1);
        fw_clear();
        chk(!irq, "R5 cleared", int'(irq), 0);
        expect_silence("R3 bank1 not ready");
        fw_write(2, 8'h20);
        fw_ready();
        chk(!st_wr_bank, "R7 switch back to bank0", int'(st_wr_bank), 0);
        send_collect(-1);
        check_bytes(2, 8'h20, "R8 bank1 second");
        @(negedge clk); cfg_irq_en = 1'b0;
        @(negedge clk);
        chk(!irq && st_done, "R5 disabled irq", int'(irq), 0);
        cfg_irq_en = 1'b1;
        fw_write(1, 8'h50);
        fw_ready();
        send_collect(-1);
        check_bytes(1, 8'h50, "R8 bank0 again");
        set_enable(1'b0, 1'b1);
        set_enable(1'b1, 1'b1);
        chk(!st_wr_bank && !st_done, "R1 pointers reset", int'(st_wr_bank), 0);
        fw_write(2, 8'h70);
        fw_ready();
        send_collect(-1);
        check_bytes(2, 8'h70, "R8 read pointer reset");
    endtask

    task automatic rx_packet(input int n, input int base, input bit crc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            out_valid = 1'b1;
            out_data  = DW'(base + i);
        end
        @(negedge clk);
        out_valid = 1'b0; out_end = 1'b1; out_crc_ok = crc;
        @(negedge clk);
        out_end = 1'b0; out_crc_ok = 1'b0;
    endtask

    task automatic t_rx();
        rx_packet(3, 8'hA0, 1'b1);
        chk(rx_pkt_ok, "R11 good pulse", int'(rx_pkt_ok), 1);
        chk(rx_len == CW'(3), "R11 length", int'(rx_len), 3);
        rx_rd_addr = AW'(2); #1;
        chk(rx_rd_data == 8'hA2, "R11 stored byte", int'(rx_rd_data), 8'hA2);
        @(negedge clk);
        chk(!rx_pkt_ok, "R11 single pulse", int'(rx_pkt_ok), 0);
        rx_packet(DEPTH + 4, 0, 1'b1);
        chk(rx_pkt_ok, "R11 valid despite overflow", int'(rx_pkt_ok), 1);
        chk(rx_len == CW'(DEPTH), "R11 length capped", int'(rx_len), DEPTH);
        rx_rd_addr = AW'(DEPTH - 1); #1;
        chk(rx_rd_data == DW'(DEPTH - 1), "R11 excess discarded", int'(rx_rd_data), DEPTH - 1);
        rx_packet(2, 8'h33, 1'b0);
        chk(!rx_pkt_ok, "R11 bad crc", int'(rx_pkt_ok), 0);
        chk(rx_len == CW'(2), "R11 bad crc length", int'(rx_len), 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_standard();
        t_overflow();
        t_pingpong();
        t_rx();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule